// File: doc/BRIEF.md
# Streaming 2x2 Cluster Trigger

This block looks for local energy deposits in one calorimeter region. Each input word is the 12-bit summed amplitude of a 2x2 group of towers, so a 2x2 window of inputs spans 4x4 towers. The block receives a region as a stream of such words, at most one per clock, and forms the sum of every 2x2 window while the data goes by. It keeps only one stored value and one vertical pair sum per window row. Each window sum is compared with a threshold. That threshold is a base value plus a share of an external multiplicity figure, so the cut rises with detector occupancy.

The region has ROWS x COLS inputs, 4 x 24 by default. The upstream logic extends the stream so that windows on the border can be completed. Each column carries one extra value at its bottom, taken from the region below. One extra column is sent last, taken from the side neighbour, and its bottom value comes from the diagonal neighbour. The stream therefore holds (ROWS+1) x (COLS+1) values. Columns are sent in scan order (scan column 0 first), and each column runs from its top row down to its bottom row.

A window that passes the threshold produces a one-cycle hit pulse. The pulse carries the scan row and scan column of the window's top-left input and the window sum. A done pulse marks the end of the region. A start-of-region pulse starts each region and clears the datapath. The input-valid signal may drop for any number of cycles between values.

Top module: `clus2x2_trig`

## Requirements
- R1: While reset is held and after its release, `hit_o` and `done_o` are 0 and `hit_row_o`, `hit_col_o` and `hit_sum_o` are 0.
- R2: Value k of a region (counting from 0) belongs to scan column k / 5 and scan row k % 5. Window (r, c), with r in 0..ROWS-1 and c in 0..COLS-1, covers scan rows r and r+1 and scan columns c and c+1. A hit reports r on `hit_row_o` and c on `hit_col_o`.
- R3: `hit_sum_o` is the exact sum of the four window inputs in 14 bits, including the case where all four inputs are 4095 (sum 16380).
- R4: The threshold is min(`thr_base_i` + floor(`mult_i` * 3 / 2), 16383). A window fires exactly when its sum is greater than or equal to this threshold.
- R5: Windows in the bottom window row use scan row ROWS, which holds the neighbour below. Windows in the last window column use scan column COLS, which holds the side neighbour. Window (ROWS-1, COLS-1) also uses the diagonal neighbour value, which is the final value of the stream.
- R6: The result of window (r, c) appears on the outputs in the clock cycle after the input (r+1, c+1) is accepted. The hit pulse lasts exactly one cycle.
- R7: `done_o` pulses for one cycle, in the cycle after the final value (scan row ROWS, scan column COLS) is accepted. This is the same cycle that shows the result of the last window.
- R8: A cycle with `in_valid_i` low changes no state and produces no hit and no done. Gaps of any length between values do not change the results.
- R9: `sor_i` restarts the scan at scan row 0, scan column 0 and clears the datapath. If `in_valid_i` is high in the same cycle, that value becomes the first value of the new region. If it is low, the next valid value becomes the first value.
- R10: Valid values that arrive before any `sor_i`, or after a region's final value and before the next `sor_i`, are ignored and produce no hit and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sor_i | input | 1 | Start of region; restarts the scan and clears the accumulators |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| in_data_i | input | 12 | Amplitude of one 2x2 tower group |
| thr_base_i | input | 14 | Base threshold |
| mult_i | input | 8 | Multiplicity figure that raises the threshold |
| hit_o | output | 1 | One-cycle pulse for a window at or above threshold |
| hit_row_o | output | 3 | Scan row of the firing window's top-left input |
| hit_col_o | output | 5 | Scan column of the firing window's top-left input |
| hit_sum_o | output | 14 | Sum of the firing window |
| done_o | output | 1 | One-cycle pulse after the last window of a region |

## Verification
The hardest cases to reach from the ports are the windows that need neighbour data. The diagonal corner is completed only by the very last value of the stream, and its result must coincide with the done pulse. The bench places isolated hot values in the neighbour row, the neighbour column and the corner, and sets thresholds so that only those windows can fire. It also builds a window whose sum equals the multiplicity-corrected threshold exactly. A restart with `sor_i` in the middle of a region is reached by abandoning a partly sent region of full-scale data and then sending a clean one, with and without a value in the restart cycle. Idle gaps are inserted in a pattern tied to the scan position, so that stalls fall both inside columns and at column boundaries.

// File: rtl/clus2x2_pkg.sv
package clus2x2_pkg;

   // Scan state of the region stream
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_e;

   // Index width for a counter that spans n positions
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/clus2x2_thr.sv
module clus2x2_thr #(
   parameter int SUM_W    = 14,
   parameter int MULT_W   = 8,
   parameter int GAIN     = 3,
   parameter int SHIFT    = 1,
   parameter bit SATURATE = 1'b1,
   localparam int GAIN_W  = $clog2(GAIN + 1),
   localparam int PROD_W  = MULT_W + GAIN_W,
   localparam int TOT_W   = ((SUM_W > PROD_W) ? SUM_W : PROD_W) + 1
) (
   input  logic [SUM_W-1:0]  base_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic [SUM_W-1:0]  thr_o
);

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] adj;
   logic [TOT_W-1:0]  total;

   always_comb begin
      prod  = PROD_W'(mult_i) * PROD_W'(GAIN);
      adj   = prod >> SHIFT;
      total = TOT_W'(base_i) + TOT_W'(adj);
   end

   generate
      if (SATURATE) begin : g_sat
         localparam logic [TOT_W-1:0] TOP = TOT_W'({SUM_W{1'b1}});
         always_comb begin
            thr_o = (total > TOP) ? {SUM_W{1'b1}} : total[SUM_W-1:0];
         end
         // the correction only ever raises the cut
         always_comb begin
            AST_THR_FLOOR: assert (thr_o >= base_i) else $error("threshold below base"); // R4
         end
      end else begin : g_wrap
         always_comb begin
            thr_o = total[SUM_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/clus2x2_colacc.sv
module clus2x2_colacc #(
   parameter int ROWS    = 4,
   parameter int DATA_W  = 12,
   parameter int ROW_W   = 3,
   localparam int PAIR_W = DATA_W + 1,
   localparam int SUM_W  = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic              first_col_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              win_valid_o,
   output logic [ROW_W-1:0]  win_row_o,
   output logic [SUM_W-1:0]  win_sum_o
);

   logic [DATA_W-1:0] prev_q;
   logic [PAIR_W-1:0] pair_q [ROWS];
   logic [PAIR_W-1:0] pair_new;
   logic [PAIR_W-1:0] pair_old;
   logic              pair_wr;
   logic [ROW_W-1:0]  slot;
   logic              any_nz;

   // vertical pair of this column, and the stored pair of the previous column
   always_comb begin
      pair_new = PAIR_W'(prev_q) + PAIR_W'(data_i);
      pair_wr  = take_i && (row_i != '0);
      slot     = row_i - ROW_W'(1);
      pair_old = '0;
      for (int k = 0; k < ROWS; k++) begin
         if (slot == ROW_W'(k)) pair_old = pair_q[k];
      end
      win_valid_o = pair_wr && !first_col_i;
      win_row_o   = slot;
      win_sum_o   = SUM_W'(pair_old) + SUM_W'(pair_new);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_q <= '0;
      else if (take_i) prev_q <= data_i;
      else if (clr_i)  prev_q <= '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         for (int k = 0; k < ROWS; k++) pair_q[k] <= '0;
      end else if (pair_wr) begin
         for (int k = 0; k < ROWS; k++) begin
            if (slot == ROW_W'(k)) pair_q[k] <= pair_new;
         end
      end
   end

   always_comb begin
      any_nz = (prev_q != '0);
      for (int k = 0; k < ROWS; k++) any_nz = any_nz || (pair_q[k] != '0);
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !take_i) |=> !any_nz) else $error("clear left state"); // R9

   AST_WIN_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> (win_row_o < ROW_W'(ROWS))) else $error("window row out of range"); // R2

endmodule

// File: rtl/clus2x2_cmp.sv
module clus2x2_cmp #(
   parameter int ROWS  = 4,
   parameter int COLS  = 24,
   parameter int ROW_W = 3,
   parameter int COL_W = 5,
   parameter int SUM_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_valid_i,
   input  logic [ROW_W-1:0] win_row_i,
   input  logic [COL_W-1:0] win_col_i,
   input  logic [SUM_W-1:0] win_sum_i,
   input  logic [SUM_W-1:0] thr_i,
   input  logic             last_i,
   output logic             hit_o,
   output logic [ROW_W-1:0] hit_row_o,
   output logic [COL_W-1:0] hit_col_o,
   output logic [SUM_W-1:0] hit_sum_o,
   output logic             done_o
);

   logic fire;

   always_comb fire = win_valid_i && (win_sum_i >= thr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_o     <= 1'b0;
         hit_row_o <= '0;
         hit_col_o <= '0;
         hit_sum_o <= '0;
         done_o    <= 1'b0;
      end else begin
         hit_o     <= fire;
         done_o    <= last_i;
         hit_row_o <= fire ? win_row_i : '0;
         hit_col_o <= fire ? win_col_i : '0;
         hit_sum_o <= fire ? win_sum_i : '0;
      end
   end

   AST_HIT_POS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (hit_row_o < ROW_W'(ROWS)) && (hit_col_o < COL_W'(COLS)))
      else $error("hit position out of range"); // R2

   AST_HIT_MEETS_THR: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (hit_sum_o >= $past(thr_i))) else $error("hit below threshold"); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done longer than one cycle"); // R7

endmodule

// File: rtl/clus2x2_trig.sv
module clus2x2_trig
   import clus2x2_pkg::*;
#(
   parameter int ROWS     = 4,
   parameter int COLS     = 24,
   parameter int DATA_W   = 12,
   parameter int MULT_W   = 8,
   parameter int GAIN     = 3,
   parameter int SHIFT    = 1,
   parameter bit SATURATE = 1'b1,
   localparam int SCAN_H  = ROWS + 1,
   localparam int SCAN_W  = COLS + 1,
   localparam int SUM_W   = DATA_W + 2,
   localparam int ROW_W   = idx_w(SCAN_H),
   localparam int COL_W   = idx_w(SCAN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sor_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic [SUM_W-1:0]  thr_base_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic              hit_o,
   output logic [ROW_W-1:0]  hit_row_o,
   output logic [COL_W-1:0]  hit_col_o,
   output logic [SUM_W-1:0]  hit_sum_o,
   output logic              done_o
);

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_geom
         $error("region must have at least one window row and column");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("data width too small");
      end
      if (GAIN < 1 || SHIFT < 0 || SHIFT > 16) begin : g_bad_corr
         $error("multiplicity correction out of range");
      end
   endgenerate

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS);

   scan_e            st_q;
   logic [ROW_W-1:0] row_q, cur_row;
   logic [COL_W-1:0] col_q, cur_col;
   logic             take, last;
   logic             win_valid;
   logic [ROW_W-1:0] win_row;
   logic [COL_W-1:0] win_col;
   logic [SUM_W-1:0] win_sum;
   logic [SUM_W-1:0] thr;

   // scan position of the value on the input this cycle
   always_comb begin
      take    = in_valid_i && (sor_i || (st_q == SCAN_RUN));
      cur_row = sor_i ? '0 : row_q;
      cur_col = sor_i ? '0 : col_q;
      last    = take && (cur_row == ROW_LAST) && (cur_col == COL_LAST);
      win_col = cur_col - COL_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SCAN_IDLE;
         row_q <= '0;
         col_q <= '0;
      end else if (take) begin
         if (last) begin
            st_q  <= SCAN_IDLE;
            row_q <= '0;
            col_q <= '0;
         end else begin
            st_q <= SCAN_RUN;
            if (cur_row == ROW_LAST) begin
               row_q <= '0;
               col_q <= cur_col + COL_W'(1);
            end else begin
               row_q <= cur_row + ROW_W'(1);
               col_q <= cur_col;
            end
         end
      end else if (sor_i) begin
         st_q  <= SCAN_RUN;
         row_q <= '0;
         col_q <= '0;
      end
   end

   clus2x2_colacc #(
      .ROWS   (ROWS),
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W)
   ) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (sor_i),
      .take_i      (take),
      .row_i       (cur_row),
      .first_col_i (cur_col == '0),
      .data_i      (in_data_i),
      .win_valid_o (win_valid),
      .win_row_o   (win_row),
      .win_sum_o   (win_sum)
   );

   clus2x2_thr #(
      .SUM_W    (SUM_W),
      .MULT_W   (MULT_W),
      .GAIN     (GAIN),
      .SHIFT    (SHIFT),
      .SATURATE (SATURATE)
   ) u_thr (
      .base_i (thr_base_i),
      .mult_i (mult_i),
      .thr_o  (thr)
   );

   clus2x2_cmp #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .SUM_W (SUM_W)
   ) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_valid_i (win_valid),
      .win_row_i   (win_row),
      .win_col_i   (win_col),
      .win_sum_i   (win_sum),
      .thr_i       (thr),
      .last_i      (last),
      .hit_o       (hit_o),
      .hit_row_o   (hit_row_o),
      .hit_col_o   (hit_col_o),
      .hit_sum_o   (hit_sum_o),
      .done_o      (done_o)
   );

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid_i) |-> (!hit_o && !done_o)) else $error("output without input"); // R8

endmodule

// File: tb/tb_clus2x2_trig.sv
module tb_clus2x2_trig;

   localparam int NR = 5;   // scan rows incl. neighbour
   localparam int NC = 25;  // scan columns incl. neighbour

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sor = 1'b0;
   logic        vld = 1'b0;
   logic [11:0] dat = '0;
   logic [13:0] tbase = '0;
   logic [7:0]  mu = '0;
   logic        hit_o;
   logic [2:0]  hit_row_o;
   logic [4:0]  hit_col_o;
   logic [13:0] hit_sum_o;
   logic        done_o;

   int nchk = 0;
   int nerr = 0;
   int grid [NR][NC];

   always #2.5 clk = ~clk;

   clus2x2_trig dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sor_i      (sor),
      .in_valid_i (vld),
      .in_data_i  (dat),
      .thr_base_i (tbase),
      .mult_i     (mu),
      .hit_o      (hit_o),
      .hit_row_o  (hit_row_o),
      .hit_col_o  (hit_col_o),
      .hit_sum_o  (hit_sum_o),
      .done_o     (done_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int thr_model(input int base, input int m);
      int t = base + ((m * 3) >> 1);
      return (t > 16383) ? 16383 : t;
   endfunction

   task automatic clear_grid();
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) grid[r][c] = 0;
   endtask

   // Sends the grid as one region and checks every cycle against the model.
   task automatic run_region(input int base, input int m, input bit gaps,
                             input bit pre_sor, input string req);
      int thr = thr_model(base, m);
      tbase = 14'(base);
      mu    = 8'(m);
      if (pre_sor) begin
         @(negedge clk); sor = 1'b1; vld = 1'b0;
         @(posedge clk); #1;
         chk("R9", "hit on bare start", hit_o, 0);
      end
      for (int c = 0; c < NC; c++) begin
         for (int r = 0; r < NR; r++) begin
            int  s;
            bit  eh;
            bit  el;
            @(negedge clk);
            vld = 1'b1;
            dat = 12'(grid[r][c]);
            sor = !pre_sor && (r == 0) && (c == 0);
            @(posedge clk); #1;
            s  = 0;
            eh = 1'b0;
            if (r > 0 && c > 0) begin
               s  = grid[r-1][c-1] + grid[r][c-1] + grid[r-1][c] + grid[r][c];
               eh = (s >= thr);
            end
            el = (r == NR-1) && (c == NC-1);
            chk(req, $sformatf("hit flag win(%0d,%0d)", r-1, c-1), int'(hit_o), int'(eh));
            if (eh && hit_o) begin
               chk("R2", "hit row", int'(hit_row_o), r-1);
               chk("R2", "hit col", int'(hit_col_o), c-1);
               chk("R3", "hit sum", int'(hit_sum_o), s);
            end
            chk("R7", "done flag", int'(done_o), int'(el));
            if (gaps) begin
               for (int g = 0; g < (r + c) % 3; g++) begin
                  @(negedge clk); vld = 1'b0; sor = 1'b0;
                  @(posedge clk); #1;
                  chk("R8", "hit in gap", int'(hit_o), 0);
                  chk("R8", "done in gap", int'(done_o), 0);
               end
            end
         end
      end
      @(negedge clk); vld = 1'b0; sor = 1'b0;
      @(posedge clk); #1;
      chk("R6", "hit lasts one cycle", int'(hit_o), 0);
      chk("R7", "done lasts one cycle", int'(done_o), 0);
   endtask

   // Valid values with no region open: nothing may come out.
   task automatic send_ignored(input int n, input string req);
      tbase = '0;
      mu    = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); vld = 1'b1; sor = 1'b0; dat = 12'hFFF;
         @(posedge clk); #1;
         chk(req, "hit on ignored value", int'(hit_o), 0);
         chk(req, "done on ignored value", int'(done_o), 0);
      end
      @(negedge clk); vld = 1'b0;
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      chk("R1", "hit in reset", int'(hit_o), 0);
      chk("R1", "done in reset", int'(done_o), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1", "hit after reset", int'(hit_o), 0);
      chk("R1", "row after reset", int'(hit_row_o), 0);
      chk("R1", "col after reset", int'(hit_col_o), 0);
      chk("R1", "sum after reset", int'(hit_sum_o), 0);
      chk("R1", "done after reset", int'(done_o), 0);
   endtask

   task automatic t_interior();
      clear_grid();
      grid[2][10] = 1000;
      run_region(900, 0, 1'b0, 1'b0, "R6");
      clear_grid();
      grid[0][0] = 700; grid[3][17] = 1500;
      run_region(600, 0, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_border();
      clear_grid();
      grid[4][24] = 3000;
      grid[4][5]  = 2500;
      grid[2][24] = 2200;
      run_region(2000, 0, 1'b0, 1'b0, "R5");
   endtask

   task automatic t_full_scale();
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) grid[r][c] = 4095;
      run_region(16380, 0, 1'b0, 1'b0, "R3");
      run_region(16300, 255, 1'b0, 1'b0, "R4");
   endtask

   task automatic ramp_grid();
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) grid[r][c] = ((r * 25 + c) * 37) % 600;
      grid[0][0] = 287; grid[1][0] = 288; grid[0][1] = 287; grid[1][1] = 288;
   endtask

   task automatic t_multiplicity();
      ramp_grid();
      run_region(1000, 100, 1'b0, 1'b0, "R4");   // threshold 1150, window (0,0) equals it
      run_region(1000, 101, 1'b0, 1'b0, "R4");   // threshold 1151, window (0,0) misses
      run_region(0, 255, 1'b0, 1'b0, "R4");
   endtask

   task automatic t_stall();
      ramp_grid();
      run_region(900, 40, 1'b1, 1'b0, "R8");
   endtask

   task automatic t_restart();
      tbase = 14'd1; mu = '0;
      @(negedge clk); sor = 1'b1; vld = 1'b1; dat = 12'hFFF;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); sor = 1'b0; vld = 1'b1; dat = 12'hFFF;
      end
      @(negedge clk); vld = 1'b0;
      clear_grid();
      grid[1][1] = 2000;
      run_region(1500, 0, 1'b0, 1'b0, "R9");
      @(negedge clk); sor = 1'b1; vld = 1'b1; dat = 12'hFFF;
      for (int i = 0; i < 23; i++) begin
         @(negedge clk); sor = 1'b0; vld = 1'b1; dat = 12'hFFF;
      end
      @(negedge clk); vld = 1'b0;
      clear_grid();
      grid[3][12] = 1800;
      run_region(1500, 0, 1'b1, 1'b1, "R9");
   endtask

   initial begin : watchdog
      #1000000;
      nerr++;
      nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      t_reset();
      send_ignored(30, "R10");
      t_interior();
      send_ignored(12, "R10");
      t_border();
      t_full_scale();
      t_multiplicity();
      t_stall();
      t_restart();
      repeat (3) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule